// File: doc/BRIEF.md
# Sine/Cosine Offset-Binary Lookup Stage

This stage turns a 13-bit phase code into one 12-bit sample of a sinusoid in offset-binary form, that is, a signed value shifted up by midscale. A select input picks sine or cosine. The angle for code `p` is taken at the centre of its phase step, `2*pi*(p + 0.5)/8192`. Because of this, the waveform is exactly symmetric about every quadrant boundary and never lands on a zero crossing. It sits behind a phase accumulator in a synthesizer pipeline and adds exactly one clock of latency, which the surrounding pipeline can allow for.

In full-precision mode the sample is `2047*f(angle) + 2048`. In reduced-precision mode the top byte of the output is a separately rounded 8-bit sample, `127*f(angle) + 128`, and the four low bits are forced to zero. A downstream stage that needs only 8 bits therefore gets a correctly rounded byte, rather than a truncated 12-bit value. The amplitudes come from a quarter-wave magnitude table that is computed with integer arithmetic while the design is elaborated. The other three quadrants are produced by mirroring the table address and negating around midscale.

Top module: `sincos_lut`

## Requirements
- R1: With `full_prec`=1 and `sine_sel`=1, one clock after the inputs are sampled `smp` is within 1 of `2047*sin(2*pi*(phase+0.5)/8192) + 2048`.
- R2: With `full_prec`=1 and `sine_sel`=0, `smp` is within 1 of `2047*cos(2*pi*(phase+0.5)/8192) + 2048`.
- R3: At phase 0 in full precision, `smp` is exactly 2049 (0x801) for sine and exactly 4095 (0xFFF) for cosine.
- R4: With `full_prec`=0, `smp[11:4]` is within 1 of `127*f(2*pi*(phase+0.5)/8192) + 128`, where f is sine when `sine_sel`=1 and cosine otherwise, and `smp[3:0]` is 0.
- R5: `smp` changes only at a rising clock edge and reflects the inputs sampled at that edge: the latency is one clock.
- R6: While `rst_n` is low, `smp` is held at midscale 2048 (0x800) from the first rising edge on.
- R7: `smp` is never zero. In full precision it lies in 1..4095, and in reduced precision the top byte lies in 1..255.
- R8: The cosine sample at phase `p` equals exactly the sine sample at phase `(p+2048) mod 8192`, in both precision modes.
- R9: In sine mode, the samples at `p` and `(p+4096) mod 8192` sum to exactly 4096 in full precision, and their top bytes sum to exactly 256 in reduced precision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; output register updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset; sets the output to midscale |
| phase | input | 13 | Phase code; one code is 1/8192 of a turn |
| sine_sel | input | 1 | 1 selects sine, 0 selects cosine |
| full_prec | input | 1 | 1 gives 12-bit output; 0 gives a rounded byte in bits 11:4 with bits 3:0 zero |
| smp | output | 12 | Registered offset-binary sample |

## Verification
A wrong table entry appears as a sample more than one count away from the analytic value. It shows up on the clock after that phase code is applied, and only for the codes that map to that entry through the quadrant mirroring, so the bench applies all 8192 codes in every mode. A fault in the quadrant or sign logic breaks the exact identities between samples a quarter turn and half a turn apart. These checks catch an error of one count that the ±1 tolerance would accept. Latency and reset faults are visible on the first edge after the inputs change.

// File: rtl/sincos_lut.sv
module sincos_lut #(
  parameter int PW = 13,
  parameter int OW = 12,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] phase,
  input  logic          sine_sel,
  input  logic          full_prec,
  output logic [OW-1:0] smp
);
  localparam int QW   = PW - 2;
  localparam int QN   = 1 << QW;
  localparam int AMP  = (1 << (OW - 1)) - 1;
  localparam int RAMP = (1 << (RW - 1)) - 1;
  localparam int MID  = 1 << (OW - 1);
  localparam int RMID = 1 << (RW - 1);
  localparam longint PI_Q40 = 64'sd3454217652357;
  localparam longint HALF30 = 64'sd1 << 29;

  function automatic longint sin_q30(input int idx);
    longint x, x2, t, s;
    x  = (longint'(2 * idx + 1) * PI_Q40) >>> (PW + 10);
    x2 = (x * x) >>> 30;
    t  = x;
    s  = x;
    for (int k = 1; k < 8; k++) begin
      t = -((t * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
      s = s + t;
    end
    if (s < 0) s = 0;
    return s;
  endfunction

  logic [OW-2:0] mag_f [QN];
  logic [RW-2:0] mag_r [QN];

  for (genvar i = 0; i < QN; i++) begin : g_tab
    localparam longint S = sin_q30(i);
    assign mag_f[i] = (OW-1)'((S * longint'(AMP) + HALF30) >>> 30);
    assign mag_r[i] = (RW-1)'((S * longint'(RAMP) + HALF30) >>> 30);
  end

  logic [PW-1:0] ph;
  logic [1:0]    quad;
  logic [QW-1:0] idx;
  logic [OW-2:0] mf;
  logic [RW-2:0] mr;
  logic [OW-1:0] full_v;
  logic [RW-1:0] rnd_v;

  assign ph     = sine_sel ? phase : phase + PW'(QN);
  assign quad   = ph[PW-1:PW-2];
  assign idx    = quad[0] ? ~ph[QW-1:0] : ph[QW-1:0];
  assign mf     = mag_f[idx];
  assign mr     = mag_r[idx];
  assign full_v = quad[1] ? OW'(MID) - {1'b0, mf} : OW'(MID) + {1'b0, mf};
  assign rnd_v  = quad[1] ? RW'(RMID) - {1'b0, mr} : RW'(RMID) + {1'b0, mr};

  always_ff @(posedge clk) begin
    if (!rst_n)         smp <= OW'(MID);
    else if (full_prec) smp <= full_v;
    else                smp <= {rnd_v, {(OW - RW){1'b0}}};
  end
endmodule

module sincos_lut_chk #(
  parameter int PW = 13,
  parameter int OW = 12,
  parameter int RW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] phase,
  input logic          sine_sel,
  input logic          full_prec,
  input logic [OW-1:0] smp
);
  localparam int MID = 1 << (OW - 1);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst_n;

  AST_RESET_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q == 1'b0) |-> (smp == OW'(MID))); // R6

  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    smp != '0); // R7

  AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(full_prec)) |-> (smp[OW-RW-1:0] == '0)); // R4

  AST_TOP_BYTE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(full_prec)) |-> (smp[OW-1:OW-RW] != '0)); // R7

  AST_SINE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(full_prec) && $past(sine_sel) && $past(phase) == '0)
      |-> (smp == OW'(MID + 1))); // R3

  AST_COSINE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(full_prec) && !$past(sine_sel) && $past(phase) == '0)
      |-> (smp == '1)); // R3
endmodule

bind sincos_lut sincos_lut_chk #(.PW(PW), .OW(OW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase),
  .sine_sel(sine_sel), .full_prec(full_prec), .smp(smp)
);

// File: tb/tb_sincos_lut.sv
`timescale 1ns/1ps
module tb_sincos_lut;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] phase = '0;
  logic        sine_sel = 1'b1;
  logic        full_prec = 1'b1;
  logic [11:0] smp;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int res [4][8192];

  always #2 clk = ~clk;

  sincos_lut dut (.clk(clk), .rst_n(rst_n), .phase(phase),
                  .sine_sel(sine_sel), .full_prec(full_prec), .smp(smp));

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic chk_real(input string req, input int act, input real ex);
    real d;
    d = real'(act) - ex;
    checks++;
    if (d > 1.0 || d < -1.0) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0.3f", req, act, ex);
    end
  endtask

  initial begin
    real ang, f;
    int  got;
    repeat (3) @(negedge clk);
    chk(smp == 12'h800, "R6", smp, 2048);
    phase = 13'd0; sine_sel = 1'b1; full_prec = 1'b1;
    @(negedge clk);
    chk(smp == 12'h800, "R6", smp, 2048);
    rst_n = 1'b1;
    @(negedge clk);
    chk(smp == 12'd2049, "R3", smp, 2049);
    sine_sel = 1'b0;
    #1;
    chk(smp == 12'd2049, "R5", smp, 2049);
    @(negedge clk);
    chk(smp == 12'd4095, "R3", smp, 4095);
    chk(smp == 12'd4095, "R5", smp, 4095);

    for (int m = 0; m < 4; m++) begin
      sine_sel  = m[1];
      full_prec = m[0];
      for (int p = 0; p < 8192; p++) begin
        phase = 13'(p);
        @(negedge clk);
        got = int'(smp);
        res[m][p] = got;
        ang = 2.0 * 3.141592653589793 * (real'(p) + 0.5) / 8192.0;
        f = m[1] ? $sin(ang) : $cos(ang);
        if (m[0]) begin
          chk_real(m[1] ? "R1" : "R2", got, 2047.0 * f + 2048.0);
          chk(got >= 1 && got <= 4095, "R7", got, 1);
        end else begin
          chk_real("R4", got >> 4, 127.0 * f + 128.0);
          chk((got & 15) == 0, "R4", got & 15, 0);
          chk((got >> 4) >= 1, "R7", got >> 4, 1);
        end
      end
    end

    for (int p = 0; p < 8192; p++) begin
      int q;
      int h;
      q = (p + 2048) % 8192;
      h = (p + 4096) % 8192;
      chk(res[1][p] == res[3][q], "R8", res[1][p], res[3][q]);
      chk(res[0][p] == res[2][q], "R8", res[0][p], res[2][q]);
      chk(res[3][p] + res[3][h] == 4096, "R9", res[3][p] + res[3][h], 4096);
      chk((res[2][p] >> 4) + (res[2][h] >> 4) == 256, "R9",
          (res[2][p] >> 4) + (res[2][h] >> 4), 256);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule